// File: doc/BRIEF.md
# Processor Status Word Flag Unit

This block keeps the processor status word next to an ALU. After each update strobe it derives six status flags from the operation's operands, its result and the carry-out that the ALU reports: carry, even parity, nibble auxiliary carry, zero, sign and signed overflow. It does this for 8-bit and 16-bit operations. It also keeps three control flags. Each control flag has its own set and clear command: interrupt enable, string direction and single-step trap.

The stored control flags gate three requests, each answered one cycle later. A maskable interrupt request is answered only while interrupt enable is held. A non-maskable request is always answered. An instruction-done pulse raises a single-step request while the trap flag is held. The ALU datapath and the branch logic sit outside this block.

Top module: `psw_flag_unit`

## Requirements
- R1: While `rst` is high at a clock edge, all nine flags and all three request outputs become 0.
- R2: For an add (op_class 0) or a subtract (op_class 1), the carry flag takes `carry_out`, which is the carry or borrow out of the most significant bit. A logic operation (op_class 2) clears both the carry flag and the overflow flag.
- R3: The parity flag is 1 when `result[7:0]` has an even number of ones, in both byte mode and word mode.
- R4: For an add or a subtract, the auxiliary flag is the carry or borrow from bit 3 into bit 4 of the operands. A logic operation leaves the auxiliary flag unchanged.
- R5: Word mode (`word_sel` = 1) uses bit 15 as the most significant bit and the full 16-bit result. Byte mode uses bit 7 and the low byte only. The zero flag marks a result of 0 within that width. The sign flag copies the result's most significant bit.
- R6: The overflow flag is 1 when the signed add or subtract of the operands, taken at the selected width, falls outside that width's signed range.
- R7: The status flags change only on a clock edge where `upd_en` is 1 and op_class is 0, 1 or 2. Op_class 3 leaves them unchanged.
- R8: Each control flag is set by its set command and cleared by its clear command. Clear wins when both commands come together. An arithmetic update never changes a control flag, and explicit commands take effect in the same edge as an update.
- R9: `mask_take` is 1 in the cycle after `mask_req` only if the interrupt enable flag was already 1 before that edge.
- R10: `nmi_take` is 1 in the cycle after `nmi_req`, whatever the flags hold.
- R11: `step_req` is 1 in the cycle after `insn_done` only if the trap flag was already 1 before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_en | input | 1 | Status flag update strobe |
| op_class | input | 2 | 0 add, 1 subtract, 2 logic, 3 none |
| word_sel | input | 1 | 1 selects 16-bit width, 0 selects 8-bit width |
| opnd_a | input | 16 | First operand (minuend for a subtract) |
| opnd_b | input | 16 | Second operand (subtrahend for a subtract) |
| result | input | 16 | ALU result |
| carry_out | input | 1 | Carry or borrow out of the most significant bit |
| ien_set | input | 1 | Set interrupt enable |
| ien_clr | input | 1 | Clear interrupt enable |
| dir_set | input | 1 | Set direction (string addresses decrement) |
| dir_clr | input | 1 | Clear direction (string addresses increment) |
| trap_set | input | 1 | Set single-step trap |
| trap_clr | input | 1 | Clear single-step trap |
| insn_done | input | 1 | Instruction boundary pulse |
| mask_req | input | 1 | Maskable interrupt request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| f_carry | output | 1 | Carry flag |
| f_parity | output | 1 | Parity flag |
| f_aux | output | 1 | Auxiliary carry flag |
| f_zero | output | 1 | Zero flag |
| f_sign | output | 1 | Sign flag |
| f_ovf | output | 1 | Overflow flag |
| f_ien | output | 1 | Interrupt enable flag |
| f_dir | output | 1 | Direction flag |
| f_trap | output | 1 | Trap flag |
| mask_take | output | 1 | Accepted maskable interrupt |
| nmi_take | output | 1 | Accepted non-maskable interrupt |
| step_req | output | 1 | Single-step request |

## Verification
Two cases are hard to reach from the ports. In the first, a control command and a gated request fall on the same edge, so the request must be judged against the flag as it stood before that edge. The stimulus drives `ien_set` together with `mask_req`, and `ien_clr` together with `mask_req`, after the flag has been set up the other way. In the second, byte-mode flags must ignore the upper halves of the operands and the result. Byte operations are therefore driven with deliberately non-zero upper bytes, including a low-byte result of zero under a non-zero upper byte. A logic operation is placed after an add that set the auxiliary flag, to show that the flag survives the logic operation.

// File: rtl/psw_pkg.sv
package psw_pkg;
  typedef enum logic [1:0] {
    OP_ADD   = 2'd0,
    OP_SUB   = 2'd1,
    OP_LOGIC = 2'd2,
    OP_NONE  = 2'd3
  } op_class_e;

  typedef struct packed {
    logic cf;
    logic pf;
    logic af;
    logic zf;
    logic sf;
    logic of;
  } stat_t;

  localparam int NUM_CTRL = 3;
  localparam int CTRL_IEN  = 0;
  localparam int CTRL_DIR  = 1;
  localparam int CTRL_TRAP = 2;
endpackage

// File: rtl/psw_flag_calc.sv
module psw_flag_calc
  import psw_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int NIB_W  = 4
) (
  input  op_class_e         op,
  input  logic              word_sel,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] r,
  input  logic              cin,
  input  stat_t             cur,
  output stat_t             nxt
);
  logic msb_a, msb_b, msb_r;
  logic zero_w;
  logic ovf_add, ovf_sub;
  logic half_cy;

  always_comb begin
    msb_a  = word_sel ? a[DATA_W-1] : a[BYTE_W-1];
    msb_b  = word_sel ? b[DATA_W-1] : b[BYTE_W-1];
    msb_r  = word_sel ? r[DATA_W-1] : r[BYTE_W-1];
    zero_w = word_sel ? (r == '0) : (r[BYTE_W-1:0] == '0);
    // bit NIB_W of the result differs from a^b there exactly when a carry/borrow crossed in
    half_cy = a[NIB_W] ^ b[NIB_W] ^ r[NIB_W];
    ovf_add = (msb_a == msb_b) && (msb_r != msb_a);
    ovf_sub = (msb_a != msb_b) && (msb_r != msb_a);
  end

  always_comb begin
    nxt    = cur;
    nxt.pf = ~^r[BYTE_W-1:0];
    nxt.zf = zero_w;
    nxt.sf = msb_r;
    case (op)
      OP_ADD: begin
        nxt.cf = cin;
        nxt.af = half_cy;
        nxt.of = ovf_add;
      end
      OP_SUB: begin
        nxt.cf = cin;
        nxt.af = half_cy;
        nxt.of = ovf_sub;
      end
      OP_LOGIC: begin
        nxt.cf = 1'b0;
        nxt.of = 1'b0;
      end
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/psw_ctrl_bit.sv
module psw_ctrl_bit (
  input  logic clk,
  input  logic rst,
  input  logic set_cmd,
  input  logic clr_cmd,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= 1'b0;
    else if (clr_cmd) q <= 1'b0;
    else if (set_cmd) q <= 1'b1;
  end
endmodule

// File: rtl/psw_req_gate.sv
module psw_req_gate (
  input  logic clk,
  input  logic rst,
  input  logic ien_q,
  input  logic trap_q,
  input  logic mask_req,
  input  logic nmi_req,
  input  logic insn_done,
  output logic mask_take,
  output logic nmi_take,
  output logic step_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_take <= 1'b0;
      nmi_take  <= 1'b0;
      step_req  <= 1'b0;
    end else begin
      mask_take <= mask_req & ien_q;
      nmi_take  <= nmi_req;
      step_req  <= insn_done & trap_q;
    end
  end
endmodule

// File: rtl/psw_flag_unit.sv
module psw_flag_unit
  import psw_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_en,
  input  logic [1:0]        op_class,
  input  logic              word_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] result,
  input  logic              carry_out,
  input  logic              ien_set,
  input  logic              ien_clr,
  input  logic              dir_set,
  input  logic              dir_clr,
  input  logic              trap_set,
  input  logic              trap_clr,
  input  logic              insn_done,
  input  logic              mask_req,
  input  logic              nmi_req,
  output logic              f_carry,
  output logic              f_parity,
  output logic              f_aux,
  output logic              f_zero,
  output logic              f_sign,
  output logic              f_ovf,
  output logic              f_ien,
  output logic              f_dir,
  output logic              f_trap,
  output logic              mask_take,
  output logic              nmi_take,
  output logic              step_req
);
  localparam int BYTE_W = DATA_W / 2;

  stat_t stat_q, stat_d;
  logic [NUM_CTRL-1:0] ctrl_set, ctrl_clr, ctrl_q;

  psw_flag_calc #(
    .DATA_W(DATA_W),
    .BYTE_W(BYTE_W),
    .NIB_W (NIB_W)
  ) u_calc (
    .op      (op_class_e'(op_class)),
    .word_sel(word_sel),
    .a       (opnd_a),
    .b       (opnd_b),
    .r       (result),
    .cin     (carry_out),
    .cur     (stat_q),
    .nxt     (stat_d)
  );

  always_ff @(posedge clk) begin
    if (rst)         stat_q <= '0;
    else if (upd_en) stat_q <= stat_d;
  end

  assign ctrl_set = {trap_set, dir_set, ien_set};
  assign ctrl_clr = {trap_clr, dir_clr, ien_clr};

  for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
    psw_ctrl_bit u_bit (
      .clk    (clk),
      .rst    (rst),
      .set_cmd(ctrl_set[g]),
      .clr_cmd(ctrl_clr[g]),
      .q      (ctrl_q[g])
    );
  end

  psw_req_gate u_gate (
    .clk      (clk),
    .rst      (rst),
    .ien_q    (ctrl_q[CTRL_IEN]),
    .trap_q   (ctrl_q[CTRL_TRAP]),
    .mask_req (mask_req),
    .nmi_req  (nmi_req),
    .insn_done(insn_done),
    .mask_take(mask_take),
    .nmi_take (nmi_take),
    .step_req (step_req)
  );

  assign f_carry  = stat_q.cf;
  assign f_parity = stat_q.pf;
  assign f_aux    = stat_q.af;
  assign f_zero   = stat_q.zf;
  assign f_sign   = stat_q.sf;
  assign f_ovf    = stat_q.of;
  assign f_ien    = ctrl_q[CTRL_IEN];
  assign f_dir    = ctrl_q[CTRL_DIR];
  assign f_trap   = ctrl_q[CTRL_TRAP];
endmodule

// File: rtl/psw_flag_chk.sv
module psw_flag_chk (
  input logic       clk,
  input logic       rst,
  input logic       upd_en,
  input logic [1:0] op_class,
  input logic       ien_set,
  input logic       ien_clr,
  input logic       insn_done,
  input logic       mask_req,
  input logic       nmi_req,
  input logic       f_carry,
  input logic       f_parity,
  input logic       f_aux,
  input logic       f_zero,
  input logic       f_sign,
  input logic       f_ovf,
  input logic       f_ien,
  input logic       f_trap,
  input logic       mask_take,
  input logic       nmi_take,
  input logic       step_req
);
  assert_logic_clears_R2: assert property (@(posedge clk) disable iff (rst)
    (upd_en && op_class == 2'd2) |=> (!f_carry && !f_ovf));

  assert_aux_kept_R4: assert property (@(posedge clk) disable iff (rst)
    (upd_en && op_class == 2'd2) |=> $stable(f_aux));

  assert_no_update_R7: assert property (@(posedge clk) disable iff (rst)
    (!upd_en || op_class == 2'd3) |=>
      $stable({f_carry, f_parity, f_aux, f_zero, f_sign, f_ovf}));

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (rst)
    ien_clr |=> !f_ien);

  assert_ien_set_R8: assert property (@(posedge clk) disable iff (rst)
    (ien_set && !ien_clr) |=> f_ien);

  assert_mask_blocked_R9: assert property (@(posedge clk) disable iff (rst)
    (mask_req && !f_ien) |=> !mask_take);

  assert_nmi_pass_R10: assert property (@(posedge clk) disable iff (rst)
    nmi_req |=> nmi_take);

  assert_step_R11: assert property (@(posedge clk) disable iff (rst)
    (insn_done && f_trap) |=> step_req);
endmodule

bind psw_flag_unit psw_flag_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .upd_en   (upd_en),
  .op_class (op_class),
  .ien_set  (ien_set),
  .ien_clr  (ien_clr),
  .insn_done(insn_done),
  .mask_req (mask_req),
  .nmi_req  (nmi_req),
  .f_carry  (f_carry),
  .f_parity (f_parity),
  .f_aux    (f_aux),
  .f_zero   (f_zero),
  .f_sign   (f_sign),
  .f_ovf    (f_ovf),
  .f_ien    (f_ien),
  .f_trap   (f_trap),
  .mask_take(mask_take),
  .nmi_take (nmi_take),
  .step_req (step_req)
);

// File: tb/psw_flag_unit_test.sv
module psw_flag_unit_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic upd_en = 1'b0;
  logic [1:0] op_class = 2'd0;
  logic word_sel = 1'b0;
  logic [15:0] opnd_a = '0, opnd_b = '0, result = '0;
  logic carry_out = 1'b0;
  logic ien_set = 0, ien_clr = 0, dir_set = 0, dir_clr = 0, trap_set = 0, trap_clr = 0;
  logic insn_done = 0, mask_req = 0, nmi_req = 0;
  logic f_carry, f_parity, f_aux, f_zero, f_sign, f_ovf, f_ien, f_dir, f_trap;
  logic mask_take, nmi_take, step_req;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // expected model state: {cf,pf,af,zf,sf,of}, {ien,dir,trap}
  logic [5:0] m_stat = '0;
  logic [2:0] m_ctrl = '0;

  logic [11:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  psw_flag_unit uut (
    .clk(clk), .rst(rst), .upd_en(upd_en), .op_class(op_class), .word_sel(word_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .carry_out(carry_out),
    .ien_set(ien_set), .ien_clr(ien_clr), .dir_set(dir_set), .dir_clr(dir_clr),
    .trap_set(trap_set), .trap_clr(trap_clr), .insn_done(insn_done),
    .mask_req(mask_req), .nmi_req(nmi_req),
    .f_carry(f_carry), .f_parity(f_parity), .f_aux(f_aux), .f_zero(f_zero),
    .f_sign(f_sign), .f_ovf(f_ovf), .f_ien(f_ien), .f_dir(f_dir), .f_trap(f_trap),
    .mask_take(mask_take), .nmi_take(nmi_take), .step_req(step_req)
  );

  function automatic logic [11:0] observed();
    return {f_carry, f_parity, f_aux, f_zero, f_sign, f_ovf,
            f_ien, f_dir, f_trap, mask_take, nmi_take, step_req};
  endfunction

  // op: 0 add, 1 sub, 2 logic, 3 none; ctl = {ien_s,ien_c,dir_s,dir_c,trap_s,trap_c}
  // rq = {insn_done, mask_req, nmi_req}
  task automatic drive(input logic [1:0] op, input logic w, input logic [15:0] a,
                       input logic [15:0] b, input logic [15:0] rlog, input logic upd,
                       input logic [5:0] ctl, input logic [2:0] rq, input string tag);
    logic [16:0] s17;
    logic [8:0]  s9;
    logic [15:0] r;
    logic        c;
    int sa, sb, sr, lo, hi;
    logic [5:0] ns;
    logic [2:0] takes;
    @(negedge clk);
    r = rlog;
    c = 1'b1;
    sa = w ? int'($signed(a)) : int'($signed(a[7:0]));
    sb = w ? int'($signed(b)) : int'($signed(b[7:0]));
    lo = w ? -32768 : -128;
    hi = w ? 32767 : 127;
    if (op == 2'd0) begin
      s17 = {1'b0, a} + {1'b0, b};
      s9  = {1'b0, a[7:0]} + {1'b0, b[7:0]};
      r   = w ? s17[15:0] : {8'hA5, s9[7:0]};
      c   = w ? s17[16] : s9[8];
      sr  = sa + sb;
    end else if (op == 2'd1) begin
      s17 = {1'b0, a} - {1'b0, b};
      s9  = {1'b0, a[7:0]} - {1'b0, b[7:0]};
      r   = w ? s17[15:0] : {8'h3C, s9[7:0]};
      c   = w ? s17[16] : s9[8];
      sr  = sa - sb;
    end else begin
      sr = 0;
    end
    upd_en = upd; op_class = op; word_sel = w;
    opnd_a = a; opnd_b = b; result = r; carry_out = c;
    {ien_set, ien_clr, dir_set, dir_clr, trap_set, trap_clr} = ctl;
    {insn_done, mask_req, nmi_req} = rq;
    // gated requests judge the flags held before this edge
    takes = {rq[1] & m_ctrl[2], rq[0], rq[2] & m_ctrl[0]};
    ns = m_stat;
    if (upd && op != 2'd3) begin
      ns[4] = ($countones(r[7:0]) % 2) == 0;
      ns[2] = w ? (r == 16'h0) : (r[7:0] == 8'h0);
      ns[1] = w ? r[15] : r[7];
      if (op == 2'd2) begin
        ns[5] = 1'b0; ns[0] = 1'b0;
      end else begin
        ns[5] = c;
        ns[0] = (sr < lo) || (sr > hi);
        ns[3] = (op == 2'd0) ? ((a[3:0] + b[3:0]) > 5'd15) : (a[3:0] < b[3:0]);
      end
    end
    m_stat = ns;
    m_ctrl[2] = ctl[4] ? 1'b0 : (ctl[5] ? 1'b1 : m_ctrl[2]);
    m_ctrl[1] = ctl[2] ? 1'b0 : (ctl[3] ? 1'b1 : m_ctrl[1]);
    m_ctrl[0] = ctl[0] ? 1'b0 : (ctl[1] ? 1'b1 : m_ctrl[0]);
    exp_q.push_back({m_stat, m_ctrl, takes[2], takes[1], takes[0]});
    tag_q.push_back(tag);
    @(posedge clk);
  endtask

  // monitor: compare each pushed expectation after the edge that consumes it
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        logic [11:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (observed() !== e) begin
          errors++;
          $display("FAIL %s: got %b expected %b", t, observed(), e);
        end
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (observed() !== 12'h000) begin
      errors++;
      $display("FAIL R1 reset: got %b expected %b", observed(), 12'h000);
    end
    rst = 1'b0;

    // word add, carry out and zero: 0xFFFF + 1
    drive(2'd0, 1'b1, 16'hFFFF, 16'h0001, 16'h0, 1'b1, 6'b0, 3'b0, "R2 R5 word add carry");
    // word add signed overflow, aux from 8+8
    drive(2'd0, 1'b1, 16'h7FF8, 16'h0008, 16'h0, 1'b1, 6'b0, 3'b0, "R6 R4 word add overflow");
    // word sub borrow: 3 - 5
    drive(2'd0 + 2'd1, 1'b1, 16'h0003, 16'h0005, 16'h0, 1'b1, 6'b0, 3'b0, "R2 R4 word sub borrow");
    // word sub signed overflow: 0x8000 - 1
    drive(2'd1, 1'b1, 16'h8000, 16'h0001, 16'h0, 1'b1, 6'b0, 3'b0, "R6 word sub overflow");
    // byte add with dirty upper bytes, low byte zero: 0x80 + 0x80
    drive(2'd0, 1'b0, 16'h1280, 16'h3480, 16'h0, 1'b1, 6'b0, 3'b0, "R5 R6 byte add zero");
    // byte add, positive overflow, sign bit 7
    drive(2'd0, 1'b0, 16'hFF7F, 16'h0001, 16'h0, 1'b1, 6'b0, 3'b0, "R5 R6 byte add sign");
    // byte sub without borrow, aux borrow
    drive(2'd1, 1'b0, 16'h0050, 16'hFF0F, 16'h0, 1'b1, 6'b0, 3'b0, "R4 byte sub");
    // add setting aux, then logic: aux kept, CF/OF cleared, odd parity
    drive(2'd0, 1'b1, 16'hFFFF, 16'h0009, 16'h0, 1'b1, 6'b0, 3'b0, "R4 add aux setup");
    drive(2'd2, 1'b1, 16'h0, 16'h0, 16'h8007, 1'b1, 6'b0, 3'b0, "R2 R4 R3 logic word");
    // logic byte: result low byte 0x03 even parity, upper ignored
    drive(2'd2, 1'b0, 16'h0, 16'h0, 16'hFF03, 1'b1, 6'b0, 3'b0, "R3 R5 logic byte");
    // op_class 3 and strobe low: no change
    drive(2'd3, 1'b1, 16'h1234, 16'h1111, 16'h0000, 1'b1, 6'b0, 3'b0, "R7 op none");
    drive(2'd0, 1'b1, 16'hFFFF, 16'h0001, 16'h0, 1'b0, 6'b0, 3'b0, "R7 strobe low");
    // maskable request blocked while enable clear, nmi passes
    drive(2'd0, 1'b1, 16'h0, 16'h0, 16'h0, 1'b0, 6'b0, 3'b011, "R9 R10 mask blocked nmi");
    // set enable together with request: old flag blocks
    drive(2'd0, 1'b1, 16'h0, 16'h0, 16'h0, 1'b0, 6'b100000, 3'b010, "R9 R8 same-edge set");
    // enable held, request passes; clear with request still passes
    drive(2'd0, 1'b1, 16'h0, 16'h0, 16'h0, 1'b0, 6'b000000, 3'b010, "R9 mask pass");
    drive(2'd0, 1'b1, 16'h0, 16'h0, 16'h0, 1'b0, 6'b010000, 3'b010, "R9 R8 same-edge clear");
    // set and clear together: clear wins; with arithmetic update
    drive(2'd0, 1'b1, 16'h0001, 16'h0001, 16'h0, 1'b1, 6'b111111, 3'b0, "R8 clear wins");
    drive(2'd1, 1'b1, 16'h0001, 16'h0001, 16'h0, 1'b1, 6'b101010, 3'b0, "R8 set with update");
    // trap held: instruction done raises step; nmi alone
    drive(2'd0, 1'b1, 16'h0, 16'h0, 16'h0, 1'b0, 6'b000101, 3'b100, "R11 R8 step and dir clear");
    drive(2'd0, 1'b1, 16'h0, 16'h0, 16'h0, 1'b0, 6'b000000, 3'b100, "R11 no trap");
    drive(2'd0, 1'b1, 16'h0, 16'h0, 16'h0, 1'b0, 6'b000000, 3'b001, "R10 nmi alone");
    drive(2'd0, 1'b1, 16'h0, 16'h0, 16'h0, 1'b0, 6'b000000, 3'b000, "R10 idle");

    // reset again clears everything
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (observed() !== 12'h000) begin
      errors++;
      $display("FAIL R1 second reset: got %b expected %b", observed(), 12'h000);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule